// File: doc/BRIEF.md
# Acquisition run start/stop controller

This block decides when a digitizer board is acquiring. It produces a single run level from one of four sources picked by a two-bit mode field. The sources are a software bit, an external start level, the first trigger edge, or one selectable general-purpose input. The same software bit acts as the run bit in software mode. In the other three modes it acts as an arm bit, and without it the run never starts.

Every start and every stop passes through a programmable delay counted in clock cycles. On a daisy chain of boards, each board's delay can then make up for the time the start signal takes to travel down the chain. The run level is an output, so it can drive the start input of the next board in the chain.

The block also qualifies the trigger input. A trigger edge is passed on as a one-cycle pulse only while the board is running. In first-trigger mode, the edge that starts the run is consumed and is never passed on.

Top module: `acq_run_ctrl`

## Requirements
- R1: While reset is held and after it is released, `run` and `trg_q` are 0 until a start condition is seen.
- R2: Mode 2'b00 (software): the target run state equals `arm`. With `dly_cyc` = 0, `run` takes the value of `arm` at the first rising clock edge after `arm` changes.
- R3: Mode 2'b01 (start level): the target is `arm` AND the synchronised `sin_i`. A change on `sin_i` reaches `run` 3 edges after it is applied when the delay is 0. With `arm` = 0, `sin_i` has no effect on `run`.
- R4: Mode 2'b10 (first trigger): when armed, the first synchronised rising edge of `trgin_i` sets the target. With delay 0, `run` rises 4 edges after the input edge. That edge never appears on `trg_q`. Later edges do not stop the run. Only clearing `arm` stops it.
- R5: Mode 2'b11 (general-purpose input): behaves like mode 2'b01, using bit `gpio_i[gpio_sel]` in place of `sin_i`. Other bits of `gpio_i` have no effect.
- R6: With `dly_cyc` = D > 0, a change of the target state reaches `run` D edges later than it would with D = 0. `run` never changes on two consecutive edges.
- R7: A target change that arrives while a delayed transition is pending does not disturb it. The pending transition completes first. If the target still differs from `run` afterwards, a new transition starts one edge later and waits the full D edges.
- R8: Clearing `arm` cancels a pending start, so `run` does not rise. If the board is running, clearing `arm` brings `run` low after the delay, in every mode.
- R9: `trg_q` pulses for one cycle 3 edges after a rising edge of `trgin_i`, and only if `run` was 1 at that point. A trigger edge seen while stopped produces no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Start/stop source: 00 software, 01 start level, 10 first trigger, 11 selected GPIO |
| arm | input | 1 | Run bit in mode 00, arm bit in other modes |
| dly_cyc | input | DLY_W | Start/stop delay in clock cycles |
| sin_i | input | 1 | Asynchronous external start level |
| trgin_i | input | 1 | Asynchronous external trigger |
| gpio_i | input | GPIO_W | Asynchronous general-purpose inputs |
| gpio_sel | input | SEL_W | Index of the GPIO bit used in mode 11 |
| run | output | 1 | Delayed run state; also drives the next board in a chain |
| trg_q | output | 1 | Qualified one-cycle trigger pulse |

## Verification
The assertions check the following on every cycle:
- The delay counter steps down by one while a transition waits.
- `run` never rises without the arm bit, and never toggles on consecutive edges when a delay is set.
- A qualified trigger is only issued when the board was running.
- The first-trigger start never emits a pulse.

Only the bench scenarios can show the exact edge on which each transition lands, for each mode and delay. The same holds for a cancelled start, for a transition queued behind a pending one, and for inputs that must have no effect.

// File: rtl/acq_run_ctrl.sv
module acq_run_ctrl #(
  parameter int DLY_W  = 32,
  parameter int GPIO_W = 16,
  localparam int SEL_W = (GPIO_W > 1) ? $clog2(GPIO_W) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic             arm,
  input  logic [DLY_W-1:0] dly_cyc,
  input  logic             sin_i,
  input  logic             trgin_i,
  input  logic [GPIO_W-1:0] gpio_i,
  input  logic [SEL_W-1:0] gpio_sel,
  output logic             run,
  output logic             trg_q
);

  localparam logic [1:0] M_SW  = 2'b00;
  localparam logic [1:0] M_LVL = 2'b01;
  localparam logic [1:0] M_FT  = 2'b10;
  localparam logic [1:0] M_GP  = 2'b11;

  logic [1:0]       sin_sy, trg_sy, gp_sy;
  logic             trg_d, ft_go, tgt, pend, pend_val;
  logic [DLY_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sin_sy <= '0;
      trg_sy <= '0;
      gp_sy  <= '0;
      trg_d  <= 1'b0;
    end else begin
      sin_sy <= {sin_sy[0], sin_i};
      trg_sy <= {trg_sy[0], trgin_i};
      gp_sy  <= {gp_sy[0], gpio_i[gpio_sel]};
      trg_d  <= trg_sy[1];
    end
  end

  wire trg_rise = trg_sy[1] & ~trg_d;
  wire consume  = (mode == M_FT) & arm & ~ft_go & trg_rise;

  always_ff @(posedge clk) begin
    if (!rst_n || mode != M_FT || !arm) ft_go <= 1'b0;
    else if (consume)                   ft_go <= 1'b1;
  end

  always_comb begin
    unique case (mode)
      M_SW:    tgt = arm;
      M_LVL:   tgt = arm & sin_sy[1];
      M_FT:    tgt = arm & ft_go;
      default: tgt = arm & gp_sy[1];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run      <= 1'b0;
      pend     <= 1'b0;
      pend_val <= 1'b0;
      cnt      <= '0;
    end else if (pend) begin
      if (!arm && pend_val) pend <= 1'b0;
      else if (cnt == '0) begin
        run  <= pend_val;
        pend <= 1'b0;
      end else cnt <= cnt - 1'b1;
    end else if (tgt != run) begin
      if (dly_cyc == '0) run <= tgt;
      else begin
        pend     <= 1'b1;
        pend_val <= tgt;
        cnt      <= dly_cyc - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) trg_q <= 1'b0;
    else        trg_q <= trg_rise & run & ~consume;
  end

endmodule

module acq_run_ctrl_chk #(
  parameter int DLY_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             arm,
  input logic [DLY_W-1:0] dly_cyc,
  input logic             run,
  input logic             trg_q,
  input logic             pend,
  input logic [DLY_W-1:0] cnt,
  input logic             ft_go
);

  // R9
  qual_trg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trg_q |-> $past(run));

  // R8
  armed_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> $past(arm));

  // R6
  no_double_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run) != $past(run, 2) && dly_cyc != '0) |-> run == $past(run));

  // R7
  count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && $past(pend)) |-> cnt == $past(cnt) - 1'b1);

  // R4
  start_edge_eaten_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ft_go) |-> !trg_q);

endmodule

bind acq_run_ctrl acq_run_ctrl_chk #(.DLY_W(DLY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .arm(arm), .dly_cyc(dly_cyc), .run(run),
  .trg_q(trg_q), .pend(pend), .cnt(cnt), .ft_go(ft_go)
);

// File: tb/tb_acq_run_ctrl.sv
module tb_acq_run_ctrl;
  localparam int DW = 32;
  localparam int GW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic arm = 1'b0, sin_i = 1'b0, trgin_i = 1'b0;
  logic [DW-1:0] dly_cyc = '0;
  logic [GW-1:0] gpio_i = '0;
  logic [3:0] gpio_sel = 4'd5;
  logic run, trg_q;

  acq_run_ctrl #(.DLY_W(DW), .GPIO_W(GW)) dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .arm(arm), .dly_cyc(dly_cyc),
    .sin_i(sin_i), .trgin_i(trgin_i), .gpio_i(gpio_i), .gpio_sel(gpio_sel),
    .run(run), .trg_q(trg_q)
  );

  always #10 clk = ~clk;

  typedef struct { int k; int v; int c; string tag; } exp_t;
  exp_t q[$];
  int cyc = 0, total = 0, bad = 0, trg_seen = 0;
  logic prev_run = 1'b0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic exp_run(input int v, input int c, input string tag);
    q.push_back('{k: 0, v: v, c: c, tag: tag});
  endtask

  task automatic exp_trg(input int c, input string tag);
    q.push_back('{k: 1, v: 1, c: c, tag: tag});
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int find_exp(input int k, input int v, input int c);
    foreach (q[i]) if (q[i].k == k && q[i].v == v && q[i].c == c) return i;
    return -1;
  endfunction

  task automatic observe(input int k, input int v);
    int idx;
    idx = find_exp(k, v, cyc);
    total++;
    if (idx < 0) begin
      bad++;
      $display("FAIL unexpected %s=%0d at cycle %0d expected none (R%0s)",
               k ? "trg_q" : "run", v, cyc, k ? "9" : "6");
    end else q.delete(idx);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (run !== prev_run) begin
        observe(0, int'(run));
        prev_run = run;
      end
      if (trg_q) begin
        trg_seen++;
        observe(1, 1);
      end
    end
  end

  task automatic pulse_trg(input bit pass, input string tag);
    trgin_i = 1'b1;
    if (pass) exp_trg(cyc + 3, tag);
    tick(2);
    trgin_i = 1'b0;
    tick(3);
  endtask

  initial begin
    int t0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    chk(run == 1'b0, "R1 run after reset", int'(run), 0);
    chk(trg_q == 1'b0, "R1 trg_q after reset", int'(trg_q), 0);

    // R2 software mode, no delay
    mode = 2'b00;
    arm = 1'b1; exp_run(1, cyc + 1, "R2");
    tick(5);
    pulse_trg(1, "R9 running");
    arm = 1'b0; exp_run(0, cyc + 1, "R2");
    tick(5);
    t0 = trg_seen;
    pulse_trg(0, "R9 stopped");
    chk(trg_seen == t0, "R9 no pulse while stopped", trg_seen - t0, 0);

    // R6 delay
    dly_cyc = 7;
    arm = 1'b1; exp_run(1, cyc + 8, "R6 start");
    tick(12);
    arm = 1'b0; exp_run(0, cyc + 8, "R6 stop");
    tick(12);

    // R3 level mode
    dly_cyc = 0; mode = 2'b01;
    sin_i = 1'b1;
    tick(6);
    chk(run == 1'b0, "R3 disarmed ignores sin", int'(run), 0);
    arm = 1'b1; exp_run(1, cyc + 1, "R3 arm");
    tick(5);
    sin_i = 1'b0; exp_run(0, cyc + 3, "R3 sin low");
    tick(5);
    sin_i = 1'b1; exp_run(1, cyc + 3, "R3 sin high");
    tick(5);
    arm = 1'b0; exp_run(0, cyc + 1, "R8 disarm");
    tick(3);
    sin_i = 1'b0;
    tick(4);

    // R5 gpio mode, bit 5 selected
    mode = 2'b11; arm = 1'b1;
    gpio_i[4] = 1'b1;
    tick(6);
    chk(run == 1'b0, "R5 other gpio bit ignored", int'(run), 0);
    gpio_i[5] = 1'b1; exp_run(1, cyc + 3, "R5 gpio high");
    tick(5);
    gpio_i[5] = 1'b0; exp_run(0, cyc + 3, "R5 gpio low");
    tick(5);
    arm = 1'b0; gpio_i = '0;
    tick(4);

    // R4 first-trigger mode with delay 3
    mode = 2'b10; dly_cyc = 3;
    arm = 1'b1;
    tick(4);
    chk(run == 1'b0, "R4 armed waits for trigger", int'(run), 0);
    exp_run(1, cyc + 7, "R4 start");
    t0 = trg_seen;
    pulse_trg(0, "R4");
    tick(4);
    chk(trg_seen == t0, "R4 start edge consumed", trg_seen - t0, 0);
    pulse_trg(1, "R4 second trigger");
    sin_i = 1'b1; tick(4); sin_i = 1'b0;
    chk(run == 1'b1, "R4 run held", int'(run), 1);
    arm = 1'b0; exp_run(0, cyc + 4, "R4 stop by disarm");
    tick(8);

    // R7 queued transition
    mode = 2'b01; dly_cyc = 5; arm = 1'b1;
    tick(3);
    sin_i = 1'b1; exp_run(1, cyc + 8, "R7 first");
    exp_run(0, cyc + 14, "R7 queued");
    tick(2);
    sin_i = 1'b0;
    tick(16);
    arm = 1'b0;
    tick(3);

    // R8 cancel pending start
    mode = 2'b00; dly_cyc = 10;
    arm = 1'b1;
    tick(3);
    arm = 1'b0;
    tick(15);
    chk(run == 1'b0, "R8 pending start cancelled", int'(run), 0);

    tick(2);
    foreach (q[i]) chk(1'b0, {q[i].tag, " missing event"}, -1, q[i].c);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule